// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive observer for a single-rank SDRAM command bus. Every rising clock edge it decodes the command from clock enable, chip select, row strobe, column strobe, write enable, the bank address and the auto-precharge address bit. It follows the open/closed state of every bank and keeps counters of elapsed clocks since the events that spacing rules depend on. It never drives the bus and never looks at data.

When a command breaks a bank-state rule or a minimum spacing rule, the checker raises a sticky violation flag and records a four-bit code naming the rule. It also counts refresh commands over a fixed window of clocks and reports a shortfall at the end of each window. All limits are parameters in clock cycles. Spacing of N clocks means the later command may be issued N or more clock edges after the earlier one.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With clock enable high and chip select low, {row, column, write} strobes (active low) decode as 000 mode set, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 111 no-op. Chip select high (deselect) or clock enable low is treated as no command and has no effect.
- R2: A read or write to an open bank fewer than T_RCD (default 2) clocks after that bank's activate sets code 4.
- R3: A precharge (single, or all with A10 high) closing an open bank fewer than T_RAS (default 5) clocks after its activate sets code 5.
- R4: An activate fewer than T_RP (default 2) clocks after the bank was closed sets code 6. A read or write with A10 high closes the bank and starts this count in the cycle the access is issued.
- R5: An activate fewer than T_RC (default 7) clocks after the previous activate to the same bank sets code 7.
- R6: Two activates to any banks fewer than T_RRD (default 2) clocks apart set code 8.
- R7: Any command other than no-op or deselect fewer than T_MRD (default 2) clocks after a mode set sets code 1.
- R8: A read, write or single precharge (A10 low) to a closed bank sets code 2. An activate to an open bank sets code 3. Precharge with A10 high closes every bank without error for closed ones.
- R9: A refresh while any bank is open, or fewer than T_RP clocks after any bank was closed, sets code 9.
- R10: Every REF_WIN clocks after reset, if fewer than REF_MIN refreshes were seen in that window, code 10 is set at the window's last edge.
- R11: After reset the flag is low and the code is 0. The flag is raised with the first violation and, while it is set, flag and code hold until clr is high. When several rules fail in one cycle, the lowest code is recorded. A cycle with clr high reloads the flag and code from that cycle's own checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the latched violation |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all address bit |
| viol | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first recorded violation |

## Verification
Each command is judged at the edge that samples it, so flag and code are due one edge after the command. The bench drives a command at a falling edge and reads the outputs at the next falling edge. Spacing limits are exercised by placing the second command exactly one clock short of, or exactly at, the limit. The refresh shortfall is due at edge number 2·REF_WIN after reset release when the second window has no refresh. The bench counts edges from release and samples one edge before and at that point.

// File: rtl/sdck_pkg.sv
package sdck_pkg;

    typedef enum logic [2:0] {
        OP_IDLE, OP_MODE, OP_OPEN, OP_READ,
        OP_WRITE, OP_CLOSE, OP_REFRESH, OP_STOP
    } op_e;

    typedef enum logic [3:0] {
        E_NONE      = 4'd0,
        E_MRD       = 4'd1,
        E_IDLE_ACC  = 4'd2,
        E_REOPEN    = 4'd3,
        E_RCD       = 4'd4,
        E_RAS       = 4'd5,
        E_RP        = 4'd6,
        E_RC        = 4'd7,
        E_RRD       = 4'd8,
        E_REF_BUSY  = 4'd9,
        E_REF_RATE  = 4'd10
    } err_e;

    localparam int NUM_ERR = 11;
    typedef logic [NUM_ERR-1:0] errvec_t;

    function automatic op_e decode_op(input logic cke, input logic cs_n,
                                      input logic ras_n, input logic cas_n,
                                      input logic we_n);
        op_e r;
        if (!cke || cs_n) begin
            r = OP_IDLE;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  r = OP_MODE;
                3'b011:  r = OP_OPEN;
                3'b101:  r = OP_READ;
                3'b100:  r = OP_WRITE;
                3'b010:  r = OP_CLOSE;
                3'b001:  r = OP_REFRESH;
                3'b110:  r = OP_STOP;
                default: r = OP_IDLE;
            endcase
        end
        return r;
    endfunction

    function automatic err_e first_err(input errvec_t v);
        err_e r;
        r = E_NONE;
        for (int i = NUM_ERR - 1; i >= 1; i--) begin
            if (v[i]) r = err_e'(4'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/sdck_since.sv
module sdck_since #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst)                count <= SAT;
        else if (restart)       count <= W'(1);
        else if (count != SAT)  count <= count + W'(1);
    end
endmodule

// File: rtl/sdck_bank.sv
module sdck_bank
    import sdck_pkg::*;
#(
    parameter int TW    = 4,
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RP  = 2,
    parameter int T_RC  = 7
) (
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic sel,
    input  logic a10,
    output logic is_open,
    output logic rp_done,
    output logic e_idle_acc,
    output logic e_reopen,
    output logic e_rcd,
    output logic e_ras,
    output logic e_rp,
    output logic e_rc
);
    localparam logic [TW-1:0] L_RCD = TW'(T_RCD);
    localparam logic [TW-1:0] L_RAS = TW'(T_RAS);
    localparam logic [TW-1:0] L_RP  = TW'(T_RP);
    localparam logic [TW-1:0] L_RC  = TW'(T_RC);

    logic [TW-1:0] since_act, since_close;
    logic act_hit, acc_hit, close_cmd, closing;

    always_comb begin
        act_hit   = (op == OP_OPEN) && sel;
        acc_hit   = ((op == OP_READ) || (op == OP_WRITE)) && sel;
        close_cmd = (op == OP_CLOSE) && (sel || a10);
        closing   = is_open && (close_cmd || (acc_hit && a10));

        e_idle_acc = !is_open && (acc_hit || ((op == OP_CLOSE) && sel && !a10));
        e_reopen   = is_open && act_hit;
        e_rcd      = is_open && acc_hit && (since_act < L_RCD);
        e_ras      = is_open && close_cmd && (since_act < L_RAS);
        e_rp       = !is_open && act_hit && (since_close < L_RP);
        e_rc       = act_hit && (since_act < L_RC);
        rp_done    = (since_close >= L_RP);
    end

    always_ff @(posedge clk) begin
        if (rst)          is_open <= 1'b0;
        else if (act_hit) is_open <= 1'b1;
        else if (closing) is_open <= 1'b0;
    end

    sdck_since #(.W(TW)) u_act (
        .clk(clk), .rst(rst), .restart(act_hit), .count(since_act)
    );

    sdck_since #(.W(TW)) u_close (
        .clk(clk), .rst(rst), .restart(closing), .count(since_close)
    );
endmodule

// File: rtl/sdck_refwin.sv
module sdck_refwin #(
    parameter int REF_WIN = 6400000,
    parameter int REF_MIN = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_seen,
    output logic short_win
);
    localparam int WW = $clog2(REF_WIN);
    localparam int RW = $clog2(REF_MIN + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(REF_WIN - 1);
    localparam logic [RW-1:0] NEED     = RW'(REF_MIN);

    logic [WW-1:0] win_cnt;
    logic [RW-1:0] ref_cnt, ref_inc;
    logic          last;

    always_comb begin
        last      = (win_cnt == WIN_LAST);
        ref_inc   = (ref_seen && ref_cnt != NEED) ? ref_cnt + RW'(1) : ref_cnt;
        short_win = last && (ref_inc < NEED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            ref_cnt <= '0;
        end else if (last) begin
            win_cnt <= '0;
            ref_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + WW'(1);
            ref_cnt <= ref_inc;
        end
    end
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdck_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RP      = 2,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int REF_WIN   = 6400000,
    parameter int REF_MIN   = 4096,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            viol,
    output logic [3:0]      err_code
);
    localparam int TM1  = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int TM2  = (T_RP  > T_RC)  ? T_RP  : T_RC;
    localparam int TM3  = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int TM12 = (TM1 > TM2) ? TM1 : TM2;
    localparam int TMAX = (TM12 > TM3) ? TM12 : TM3;
    localparam int TW   = $clog2(TMAX + 1) + 1;

    op_e op;
    assign op = decode_op(cke, cs_n, ras_n, cas_n, we_n);

    logic [NUM_BANKS-1:0] b_open, b_rp_done;
    logic [NUM_BANKS-1:0] b_idle_acc, b_reopen, b_rcd, b_ras, b_rp, b_rc;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdck_bank #(
            .TW(TW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
        ) u_bank (
            .clk(clk), .rst(rst), .op(op),
            .sel(ba == BA_W'(g)), .a10(a10),
            .is_open(b_open[g]), .rp_done(b_rp_done[g]),
            .e_idle_acc(b_idle_acc[g]), .e_reopen(b_reopen[g]),
            .e_rcd(b_rcd[g]), .e_ras(b_ras[g]),
            .e_rp(b_rp[g]), .e_rc(b_rc[g])
        );
    end

    logic [TW-1:0] since_any_act, since_mode;

    sdck_since #(.W(TW)) u_rrd (
        .clk(clk), .rst(rst), .restart(op == OP_OPEN), .count(since_any_act)
    );

    sdck_since #(.W(TW)) u_mrd (
        .clk(clk), .rst(rst), .restart(op == OP_MODE), .count(since_mode)
    );

    logic short_win;

    sdck_refwin #(.REF_WIN(REF_WIN), .REF_MIN(REF_MIN)) u_refwin (
        .clk(clk), .rst(rst), .ref_seen(op == OP_REFRESH), .short_win(short_win)
    );

    errvec_t errs;
    always_comb begin
        errs               = '0;
        errs[E_MRD]        = (op != OP_IDLE) && (since_mode < TW'(T_MRD));
        errs[E_IDLE_ACC]   = |b_idle_acc;
        errs[E_REOPEN]     = |b_reopen;
        errs[E_RCD]        = |b_rcd;
        errs[E_RAS]        = |b_ras;
        errs[E_RP]         = |b_rp;
        errs[E_RC]         = |b_rc;
        errs[E_RRD]        = (op == OP_OPEN) && (since_any_act < TW'(T_RRD));
        errs[E_REF_BUSY]   = (op == OP_REFRESH) && ((|b_open) || !(&b_rp_done));
        errs[E_REF_RATE]   = short_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol     <= 1'b0;
            err_code <= E_NONE;
        end else if (clr || !viol) begin
            viol     <= |errs;
            err_code <= first_err(errs);
        end
    end
endmodule

// File: rtl/sdck_assert.sv
module sdck_assert (
    input logic       clk,
    input logic       rst,
    input logic       clr,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       viol,
    input logic [3:0] err_code
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    logic live, is_mode, is_act, is_ref;
    assign live    = cke && !cs_n;
    assign is_mode = live && !ras_n && !cas_n && !we_n;
    assign is_act  = live && !ras_n &&  cas_n &&  we_n;
    assign is_ref  = live && !ras_n && !cas_n &&  we_n;

    a_r11_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (viol && !clr) |=> (viol && $stable(err_code)));

    a_r11_clean_code: assert property (@(posedge clk) disable iff (rst)
        !viol |-> (err_code == 4'd0));

    a_r11_flag_has_code: assert property (@(posedge clk) disable iff (rst)
        viol |-> (err_code != 4'd0));

    a_r7_mode_gap: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(is_mode) && is_act && !clr) |=> viol);

    a_r9_refresh_open: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(is_act) && is_ref && !clr) |=> viol);
endmodule

bind sdram_cmd_checker sdck_assert u_sdck_assert (
    .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .viol(viol), .err_code(err_code)
);

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;
    localparam int WIN = 3000;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_DRD = 4'b1101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic a10 = 1'b0;
    logic viol;
    logic [3:0] err_code;

    int n_chk = 0;
    int n_fail = 0;
    int ecount = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sdram_cmd_checker #(.REF_WIN(WIN), .REF_MIN(2)) dut (
        .clk(clk), .rst(rst), .clr(clr), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .viol(viol), .err_code(err_code)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst) ecount++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic ev, input logic [3:0] ec);
        n_chk++;
        if (viol !== ev || err_code !== ec) begin
            n_fail++;
            $display("FAIL %s: viol=%0b code=%0d, expected viol=%0b code=%0d",
                     tag, viol, err_code, ev, ec);
        end
    endtask

    task automatic cmd(input logic [3:0] c, input int b, input logic ap);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba  = 2'(b);
        a10 = ap;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        a10 = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic settle();
        idle(8);
        cmd(C_PRE, 0, 1'b1);
        idle(8);
        clear();
    endtask

    task automatic t_reset();
        check("R11 reset state", 1'b0, 4'd0);
    endtask

    task automatic t_decode();
        settle();
        cke = 1'b0;
        cmd(C_RD, 0, 1'b0);
        cke = 1'b1;
        check("R1 clock enable low ignored", 1'b0, 4'd0);
        cmd(C_DRD, 0, 1'b0);
        check("R1 deselect ignored", 1'b0, 4'd0);
        cmd(C_WR, 3, 1'b0);
        check("R1 write decode to closed bank", 1'b1, 4'd2);
    endtask

    task automatic t_rcd();
        settle();
        cmd(C_ACT, 1, 1'b0); idle(1); cmd(C_WR, 1, 1'b0);
        check("R2 access at limit", 1'b0, 4'd0);
        settle();
        cmd(C_ACT, 1, 1'b0); cmd(C_RD, 1, 1'b0);
        check("R2 access too early", 1'b1, 4'd4);
    endtask

    task automatic t_ras();
        settle();
        cmd(C_ACT, 2, 1'b0); idle(3); cmd(C_PRE, 2, 1'b0);
        check("R3 close too early", 1'b1, 4'd5);
        settle();
        cmd(C_ACT, 2, 1'b0); idle(4); cmd(C_PRE, 2, 1'b0);
        check("R3 close at limit", 1'b0, 4'd0);
    endtask

    task automatic t_rp();
        settle();
        cmd(C_ACT, 0, 1'b0); idle(4); cmd(C_PRE, 0, 1'b0); cmd(C_ACT, 0, 1'b0);
        check("R4 reopen after precharge too early", 1'b1, 4'd6);
        settle();
        cmd(C_ACT, 3, 1'b0); idle(1); cmd(C_RD, 3, 1'b1); cmd(C_ACT, 3, 1'b0);
        check("R4 reopen after auto-precharge too early", 1'b1, 4'd6);
    endtask

    task automatic t_rc();
        settle();
        cmd(C_ACT, 0, 1'b0); idle(1); cmd(C_RD, 0, 1'b1); idle(1); cmd(C_ACT, 0, 1'b0);
        check("R5 same-bank activates too close", 1'b1, 4'd7);
        settle();
        cmd(C_ACT, 0, 1'b0); idle(1); cmd(C_RD, 0, 1'b1); idle(4); cmd(C_ACT, 0, 1'b0);
        check("R5 same-bank activates at limit", 1'b0, 4'd0);
    endtask

    task automatic t_rrd();
        settle();
        cmd(C_ACT, 0, 1'b0); cmd(C_ACT, 1, 1'b0);
        check("R6 cross-bank activates too close", 1'b1, 4'd8);
        settle();
        cmd(C_ACT, 0, 1'b0); idle(1); cmd(C_ACT, 1, 1'b0);
        check("R6 cross-bank activates at limit", 1'b0, 4'd0);
    endtask

    task automatic t_mrd();
        settle();
        cmd(C_MRS, 0, 1'b0); cmd(C_ACT, 0, 1'b0);
        check("R7 command right after mode set", 1'b1, 4'd1);
        settle();
        cmd(C_MRS, 0, 1'b0); idle(1); cmd(C_ACT, 0, 1'b0);
        check("R7 command at mode set limit", 1'b0, 4'd0);
    endtask

    task automatic t_state();
        settle();
        cmd(C_ACT, 1, 1'b0); idle(8); cmd(C_ACT, 1, 1'b0);
        check("R8 activate to open bank", 1'b1, 4'd3);
        settle();
        cmd(C_PRE, 2, 1'b0);
        check("R8 single precharge of closed bank", 1'b1, 4'd2);
        settle();
        cmd(C_ACT, 0, 1'b0); idle(1); cmd(C_ACT, 1, 1'b0); idle(6); cmd(C_PRE, 0, 1'b1);
        check("R8 precharge all accepted", 1'b0, 4'd0);
        cmd(C_RD, 0, 1'b0);
        check("R8 read after precharge all", 1'b1, 4'd2);
        settle();
        cmd(C_ACT, 2, 1'b0); idle(1); cmd(C_RD, 2, 1'b1);
        check("R8 read with auto-precharge accepted", 1'b0, 4'd0);
        idle(3); cmd(C_RD, 2, 1'b0);
        check("R8 bank closed by auto-precharge", 1'b1, 4'd2);
    endtask

    task automatic t_refresh();
        settle();
        cmd(C_REF, 0, 1'b0);
        check("R9 refresh with banks idle", 1'b0, 4'd0);
        idle(1); cmd(C_REF, 0, 1'b0);
        check("R9 second refresh", 1'b0, 4'd0);
        cmd(C_ACT, 0, 1'b0); idle(5); cmd(C_REF, 0, 1'b0);
        check("R9 refresh with open bank", 1'b1, 4'd9);
        settle();
        cmd(C_ACT, 0, 1'b0); idle(5); cmd(C_PRE, 0, 1'b0); cmd(C_REF, 0, 1'b0);
        check("R9 refresh before precharge time", 1'b1, 4'd9);
    endtask

    task automatic t_priority();
        settle();
        cmd(C_MRS, 0, 1'b0); cmd(C_RD, 1, 1'b0);
        check("R11 lowest code wins", 1'b1, 4'd1);
        idle(2); cmd(C_PRE, 3, 1'b0);
        check("R11 first error kept", 1'b1, 4'd1);
        clear();
        check("R11 clear pulse", 1'b0, 4'd0);
    endtask

    task automatic t_refrate();
        clear();
        while (ecount < 2 * WIN - 1) @(negedge clk);
        check("R10 no shortfall after served window", 1'b0, 4'd0);
        @(negedge clk);
        check("R10 shortfall at window end", 1'b1, 4'd10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_rcd();
        t_ras();
        t_rp();
        t_rc();
        t_rrd();
        t_mrd();
        t_state();
        t_refresh();
        t_priority();
        t_refrate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule